// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes one instruction per clock. It holds its own program counter, next-address logic, decoder, a 32-entry register file, an ALU with a zero flag, immediate extension and two word-addressed memories. The instruction store is a read-only array filled from a parameter. The data store is a read/write array with a combinational read and a write on the clock edge. All state (PC, registers, data words) changes on the same rising edge.

The executed set is register add and subtract, OR with a zero-extended immediate, word load and word store with a signed offset, branch-if-equal and an absolute jump within the current 256 MB region. Every other encoding leaves all state unchanged except the PC, which moves on by 4. The only outputs are debug taps: the current PC and the register write being committed in the current cycle.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 at that edge, and no register or data word is written during any cycle in which `rst_n` is low.
- R2: Opcode 0x00 with function code 0x20 writes R[rd] = R[rs] + R[rt]. Function code 0x22 writes R[rd] = R[rs] - R[rt]. Fields are op [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. Results wrap modulo 2^32.
- R3: Opcode 0x0D writes R[rt] = R[rs] OR {16'h0, imm[15:0]}.
- R4: Opcode 0x23 loads R[rt] from the data word at byte address R[rs] + sign-extended imm[15:0]. Opcode 0x2B stores R[rt] at that address. Address bits [1:0] are ignored.
- R5: Opcode 0x04 compares R[rs] with R[rt]. If they are equal, the next PC is PC + 4 + (sign-extended imm << 2). Otherwise it is PC + 4.
- R6: Opcode 0x02 sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R7: Register 0 always reads as 0. A write aimed at register 0 is dropped and does not show on the debug write port.
- R8: Any other opcode, or opcode 0x00 with any other function code, writes nothing, and the next PC is PC + 4.
- R9: `dbg_wr_en` is high in exactly the cycles in which a register is written at the next edge. In those cycles `dbg_wr_addr` and `dbg_wr_data` show that register and the value it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_pc | output | 32 | Byte address of the instruction being executed |
| dbg_wr_en | output | 1 | A register write is committed at the next edge |
| dbg_wr_addr | output | 5 | Index of the register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The test program probes cases where small decode mistakes leave visible traces. A value with bit 15 set goes through the OR-immediate, so sign-extending it instead of zero-extending it would turn 0x0000FFFF into 0xFFFFFFFF. A subtraction that goes negative would show a swapped operand order or an add in place of a subtract. A store and a load use a negative offset, so the address would be wrong if the offset were zero-extended. The program writes register 0 and then reads it back, and it runs a branch not taken, a branch taken forward, a branch back onto itself, a jump, and two unrecognised encodings. The PC is checked every cycle, so a wrong branch offset, missing shift, wrong jump splice or a no-op that stalls would break the sequence at once.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
// Package: sc_pkg
// Shared encodings and control word for the single-cycle core.
// Assumes the fixed 32-bit instruction layout (op in [31:26]).
package sc_pkg;
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;    // write the register file
        logic    dst_rd;    // destination is rd (else rt)
        logic    use_imm;   // ALU B operand is the extended immediate
        logic    imm_zext;  // zero-extend the immediate (else sign)
        logic    mem_rd;    // write-back comes from data memory
        logic    mem_wr;    // store rt to data memory
        logic    branch;    // conditional branch on ALU zero
        logic    jump;      // absolute jump
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// Module: sc_decode
// Turns the opcode and function fields into the control word.
// Assumes nothing about the other fields; unknown encodings give an
// all-zero control word, which only lets the PC move on by 4.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Control word lookup by opcode, then function code for R-type.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (op)
            OP_RTYPE: begin
                if (funct == FN_ADD) begin
                    ctrl.reg_wr = 1'b1;
                    ctrl.dst_rd = 1'b1;
                    ctrl.alu_op = ALU_ADD;
                end else if (funct == FN_SUB) begin
                    ctrl.reg_wr = 1'b1;
                    ctrl.dst_rd = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OP_LOAD: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: ctrl.jump = 1'b1;
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// Module: sc_regfile
// Two combinational read ports, one write port on the rising edge.
// Entry 0 is hard zero: its reads return 0 and its writes are dropped.
// Assumes the caller gates the write enable with reset.
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    output logic            wr_commit
);
    logic [XLEN-1:0] regs [NREG];

    assign wr_commit = we && (waddr != '0);

    // Commit the write-back value on the clock edge.
    always_ff @(posedge clk) begin
        if (wr_commit) regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// Module: sc_alu
// Add, subtract and OR, with a flag raised on a zero result.
// Assumes the operation code comes from sc_decode.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    // Select the arithmetic or logic result.
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// Module: sc_core
// Single-cycle core for the seven-instruction subset. The instruction
// store is a ROM filled from IMEM_INIT (word i at bits [32*i +: 32]).
// The data store has a combinational read and an edge write. Both are
// word-addressed and wrap on their depth. Assumes word-aligned data
// addresses; bits [1:0] are dropped.
module sc_core #(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 16,
    parameter logic [IMEM_WORDS*32-1:0] IMEM_INIT = '0,
    localparam int XLEN = 32,
    localparam int NREG = 32,
    localparam int RAW  = $clog2(NREG),
    localparam int IAW  = $clog2(IMEM_WORDS),
    localparam int DAW  = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_wr_en,
    output logic [RAW-1:0]  dbg_wr_addr,
    output logic [XLEN-1:0] dbg_wr_data
);
    import sc_pkg::*;

    logic [XLEN-1:0] pc, pc_plus4, pc_branch, pc_jump, pc_next;
    logic [31:0]     instr;
    logic [31:0]     imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    ctrl_t           ctrl;
    logic [RAW-1:0]  rs_addr, rt_addr, wr_addr;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, mem_rdata;
    logic            alu_zero, wr_commit;
    logic            unused_bits;

    // Instruction ROM built from the parameter image.
    for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
        assign imem[g] = IMEM_INIT[g*32 +: 32];
    end

    assign instr   = imem[pc[IAW+1:2]];
    assign rs_addr = instr[25:21];
    assign rt_addr = instr[20:16];

    sc_decode u_dec (
        .op    (instr[31:26]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    assign wr_addr = ctrl.dst_rd ? instr[15:11] : rt_addr;

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk       (clk),
        .we        (ctrl.reg_wr && rst_n),
        .waddr     (wr_addr),
        .wdata     (wb_data),
        .raddr_a   (rs_addr),
        .raddr_b   (rt_addr),
        .rdata_a   (rs_val),
        .rdata_b   (rt_val),
        .wr_commit (wr_commit)
    );

    assign imm_ext = ctrl.imm_zext ? {16'h0, instr[15:0]}
                                   : {{16{instr[15]}}, instr[15:0]};
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign mem_rdata = dmem[alu_y[DAW+1:2]];
    assign wb_data   = ctrl.mem_rd ? mem_rdata : alu_y;

    // Store rt into the data word on the edge.
    always_ff @(posedge clk) begin
        if (ctrl.mem_wr && rst_n) dmem[alu_y[DAW+1:2]] <= rt_val;
    end

    assign pc_plus4  = pc + 32'd4;
    assign pc_branch = pc_plus4 + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign pc_jump   = {pc_plus4[31:28], instr[25:0], 2'b00};

    // Choose the next fetch address.
    always_comb begin
        if (ctrl.jump)                     pc_next = pc_jump;
        else if (ctrl.branch && alu_zero)  pc_next = pc_branch;
        else                               pc_next = pc_plus4;
    end

    // Program counter with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign unused_bits = ^{instr[10:6], pc[1:0], alu_y[1:0]};

    assign dbg_pc      = pc;
    assign dbg_wr_en   = wr_commit;
    assign dbg_wr_addr = wr_addr;
    assign dbg_wr_data = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
// Module: sc_core_chk
// Temporal checks on the core, attached with bind. Assumes it sees the
// fetched instruction, the register read values and the ALU zero flag.
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] dbg_pc,
    input logic [31:0] instr,
    input logic [4:0]  rs_addr,
    input logic [31:0] rs_val,
    input logic        alu_zero
);
    logic [31:0] pc_seq;
    assign pc_seq = dbg_pc + 32'd4;

    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> dbg_pc == 32'd0); // R1

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] != OP_BEQ && instr[31:26] != OP_JUMP) |=> dbg_pc == $past(pc_seq)); // R8

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OP_BEQ && alu_zero) |=>
        dbg_pc == $past(pc_seq) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R5

    AST_JUMP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == OP_JUMP |=>
        dbg_pc == {$past(pc_seq[31:28]), $past(instr[25:0]), 2'b00}); // R6

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        rs_addr == 5'd0 |-> rs_val == 32'd0); // R7
endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_pc   (dbg_pc),
    .instr    (instr),
    .rs_addr  (rs_addr),
    .rs_val   (rs_val),
    .alu_zero (alu_zero)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected PCs and register writes, popped by a
// monitor each cycle at the falling edge.
module test_sc_core;
    localparam int IW = 32;

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [IW*32-1:0] build_prog();
        logic [IW*32-1:0] p;
        p = '0;
        p[ 0*32 +: 32] = enc_i(6'h0D, 0, 1, 16'h0005);          // ori r1
        p[ 1*32 +: 32] = enc_i(6'h0D, 0, 2, 16'hFFFF);          // ori r2
        p[ 2*32 +: 32] = enc_r(1, 2, 3, 6'h20);                 // add r3
        p[ 3*32 +: 32] = enc_r(1, 2, 4, 6'h22);                 // sub r4
        p[ 4*32 +: 32] = enc_i(6'h2B, 0, 3, 16'h0008);          // sw r3
        p[ 5*32 +: 32] = enc_i(6'h23, 0, 5, 16'h0008);          // lw r5
        p[ 6*32 +: 32] = enc_i(6'h0D, 1, 0, 16'h0007);          // ori r0
        p[ 7*32 +: 32] = enc_r(0, 1, 6, 6'h20);                 // add r6
        p[ 8*32 +: 32] = enc_i(6'h04, 1, 3, 16'h0005);          // beq no
        p[ 9*32 +: 32] = enc_i(6'h0D, 0, 7, 16'h0001);          // ori r7
        p[10*32 +: 32] = enc_i(6'h04, 1, 6, 16'h0002);          // beq yes
        p[11*32 +: 32] = enc_i(6'h0D, 0, 8, 16'h0BAD);          // skipped
        p[12*32 +: 32] = enc_i(6'h0D, 0, 8, 16'h0BAD);          // skipped
        p[13*32 +: 32] = {6'h02, 26'd16};                       // j 64
        p[14*32 +: 32] = enc_i(6'h0D, 0, 9, 16'h0BAD);          // skipped
        p[15*32 +: 32] = enc_i(6'h0D, 0, 9, 16'h0BAD);          // skipped
        p[16*32 +: 32] = enc_i(6'h0D, 0, 10, 16'h000C);         // ori r10
        p[17*32 +: 32] = enc_i(6'h2B, 10, 4, 16'hFFFC);         // sw r4,-4
        p[18*32 +: 32] = enc_i(6'h23, 10, 11, 16'hFFFC);        // lw r11,-4
        p[19*32 +: 32] = enc_i(6'h3F, 1, 12, 16'h0001);         // unknown op
        p[20*32 +: 32] = enc_r(1, 2, 13, 6'h21);                // unknown fn
        p[21*32 +: 32] = enc_i(6'h04, 0, 0, 16'hFFFF);          // beq self
        return p;
    endfunction

    localparam logic [IW*32-1:0] PROG = build_prog();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_addr;
    logic [31:0] dbg_wr_data;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    typedef struct { logic [31:0] pc; string tag; } pc_item_t;
    typedef struct { logic [4:0] a; logic [31:0] d; string tag; } wr_item_t;
    pc_item_t pc_q[$];
    wr_item_t wr_q[$];

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(16), .IMEM_INIT(PROG)) i_sc_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_pc      (dbg_pc),
        .dbg_wr_en   (dbg_wr_en),
        .dbg_wr_addr (dbg_wr_addr),
        .dbg_wr_data (dbg_wr_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one expected cycle, optionally with one register write.
    task automatic exp_step(input logic [31:0] pc, input bit wr, input int a,
                            input logic [31:0] d, input string tag);
        pc_item_t p;
        wr_item_t w;
        p.pc = pc; p.tag = tag;
        pc_q.push_back(p);
        if (wr) begin
            w.a = 5'(a); w.d = d; w.tag = tag;
            wr_q.push_back(w);
        end
    endtask

    // Monitor: compare PC and any committed write against the scoreboard.
    always @(negedge clk) begin
        if (mon_on && pc_q.size() > 0) begin
            pc_item_t p;
            p = pc_q.pop_front();
            check(dbg_pc == p.pc, p.tag, dbg_pc, p.pc);
            if (dbg_wr_en) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write", {27'd0, dbg_wr_addr}, 32'd0);
                end else begin
                    wr_item_t w;
                    w = wr_q.pop_front();
                    check(dbg_wr_addr == w.a, w.tag, {27'd0, dbg_wr_addr}, {27'd0, w.a});
                    check(dbg_wr_data == w.d, w.tag, dbg_wr_data, w.d);
                end
            end
        end
    end

    initial begin
        exp_step(32'd0,  1, 1,  32'h0000_0005, "R3 ori small");
        exp_step(32'd4,  1, 2,  32'h0000_FFFF, "R3 ori zero-extend");
        exp_step(32'd8,  1, 3,  32'h0001_0004, "R2 add");
        exp_step(32'd12, 1, 4,  32'hFFFF_0006, "R2 sub negative");
        exp_step(32'd16, 0, 0,  32'd0,         "R4 store");
        exp_step(32'd20, 1, 5,  32'h0001_0004, "R4 load");
        exp_step(32'd24, 0, 0,  32'd0,         "R7 write r0 dropped");
        exp_step(32'd28, 1, 6,  32'h0000_0005, "R7 r0 reads zero");
        exp_step(32'd32, 0, 0,  32'd0,         "R5 branch not taken");
        exp_step(32'd36, 1, 7,  32'h0000_0001, "R5 fall through");
        exp_step(32'd40, 0, 0,  32'd0,         "R5 branch taken");
        exp_step(32'd52, 0, 0,  32'd0,         "R5 branch target");
        exp_step(32'd64, 1, 10, 32'h0000_000C, "R6 jump target");
        exp_step(32'd68, 0, 0,  32'd0,         "R4 store negative offset");
        exp_step(32'd72, 1, 11, 32'hFFFF_0006, "R4 load negative offset");
        exp_step(32'd76, 0, 0,  32'd0,         "R8 unknown opcode");
        exp_step(32'd80, 0, 0,  32'd0,         "R8 unknown function");
        exp_step(32'd84, 0, 0,  32'd0,         "R5 backward branch");
        exp_step(32'd84, 0, 0,  32'd0,         "R5 branch to self");
        exp_step(32'd84, 0, 0,  32'd0,         "R5 branch to self");

        // R1: PC held at zero with no writes during reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dbg_pc == 32'd0, "R1 reset pc", dbg_pc, 32'd0);
        check(dbg_wr_en == 1'b0, "R1 no write in reset", {31'd0, dbg_wr_en}, 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        wait (pc_q.size() == 0);
        @(posedge clk);
        #1 mon_on = 1'b0;
        check(wr_q.size() == 0, "R9 all writes seen", 32'(wr_q.size()), 32'd0);

        // R1: reset again mid-run returns the PC to zero.
        rst_n = 1'b0;
        @(negedge clk);
        check(dbg_wr_en == 1'b0, "R1 no write in reset", {31'd0, dbg_wr_en}, 32'd0);
        @(negedge clk);
        check(dbg_pc == 32'd0, "R1 mid-run reset pc", dbg_pc, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1 watchdog", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule